// File: doc/BRIEF.md
# Memory Refresh Request Timer

This block paces periodic refresh reads for dynamic memory. It counts processor clocks. Each time a programmed number of clocks has gone by, it raises a refresh request toward the bus interface. The request carries a row address that advances by one after every refresh the bus interface accepts. Software sets the interval and turns generation on or off through a single write port. A write loads the period and the enable bit together, and it also restarts the interval count. When the processor clock rate changes, the period has to be written again.

The block also owns the grant side of an external bus-hold protocol. While no refresh is outstanding, it answers a hold request with a hold acknowledge. If a refresh falls due while the bus is lent out, the block takes the grant back by dropping the acknowledge. It then waits until the external master lowers its hold request for at least one clock, and only then presents the refresh. The bus is not lent out again until that refresh has been accepted.

The refresh request is a valid/ready output stream. `ref_valid` stays high, and `ref_addr` stays constant, until the cycle in which `ref_ready` is high. That cycle is the handshake, and it completes the refresh. The bus interface may hold `ref_ready` low for as long as it needs. A refresh that falls due during such a stall is remembered and issued later; it is not lost.

Top module: `refresh_req_timer`

## Requirements
- R1: After reset, `hold_ack` and `ref_valid` are low and `ref_addr` is 0. Generation is disabled.
- R2: A write with `cfg_enable`=1 and period P, where 2 <= P <= 511, restarts the count. With the bus free and `ref_ready` high, `ref_valid` is high exactly in the cycles P, 2P, 3P, and so on after the write edge, and each pulse lasts one cycle.
- R3: While the enable bit is 0, `ref_valid` never rises. A write with `cfg_enable`=0 also discards a refresh that is due but has not yet been presented.
- R4: `ref_addr` is 9 bits wide. It increments by one, modulo 512, on each cycle in which `ref_valid` and `ref_ready` are both high, and it is unchanged in every other cycle.
- R5: While `ref_valid` is high and `ref_ready` is low, `ref_valid` stays high and `ref_addr` is stable. A refresh that falls due during the stall is presented again one cycle after the handshake cycle.
- R6: With no refresh due, `hold_ack` rises one cycle after `hold_req` is seen high. It falls one cycle after `hold_req` is seen low.
- R7: When a refresh falls due while `hold_ack` is high, `hold_ack` drops at that same edge. No refresh is presented while `hold_req` remains high.
- R8: After a revoke, `ref_valid` rises on the edge at which `hold_req` is first sampled low.
- R9: `hold_ack` stays low from the revoke until the refresh handshake. It may rise again only on the edge after the handshake, and it is never high together with `ref_valid`.
- R10: If the enable bit is cleared while a revoked grant is waiting for the hold release, the waiting refresh is dropped. With `hold_req` still high, `hold_ack` returns one cycle after that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_period | input | 9 | Refresh interval in clocks, loaded on write |
| cfg_enable | input | 1 | Refresh enable, loaded on write |
| hold_req | input | 1 | External master bus-hold request |
| hold_ack | output | 1 | Bus-hold grant |
| ref_valid | output | 1 | Refresh request valid |
| ref_ready | input | 1 | Bus interface accepts the refresh |
| ref_addr | output | 9 | Refresh row address |

## Verification
Every result of this block appears one edge after its cause. A refresh shows on `ref_valid` at the edge where the count expires. That is exactly P edges after a write, because the write edge itself loads the count. The grant follows one edge after `hold_req` is sampled, the revoke happens at the expiry edge, and the address step and the drop of `ref_valid` come at the handshake edge. The bench drives inputs and samples outputs 1 ns after each rising edge. For every check it counts edges from the write or the input change, and it compares against that count. The period sweep predicts the pulse positions as multiples of P and tracks the expected address itself.

// File: rtl/rt_pkg.sv
package rt_pkg;
  typedef enum logic [1:0] {
    ARB_IDLE    = 2'd0,
    ARB_GRANT   = 2'd1,
    ARB_REVOKE  = 2'd2,
    ARB_REFRESH = 2'd3
  } arb_state_t;
endpackage

// File: rtl/rt_period_counter.sv
module rt_period_counter #(
  parameter int PW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [PW-1:0] load_val,
  input  logic          run,
  output logic          tick
);
  logic [PW-1:0] per_q;
  logic [PW-1:0] cnt_q;

  // expiry when the count reaches 1 (a count of 0 behaves like 1)
  assign tick = run && !load && (cnt_q[PW-1:1] == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q <= '0;
      cnt_q <= '0;
    end else if (load) begin
      per_q <= load_val;
      cnt_q <= load_val;
    end else if (tick) begin
      cnt_q <= per_q;
    end else if (run) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/rt_addr_counter.sv
module rt_addr_counter #(
  parameter int AW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  output logic [AW-1:0] addr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    addr <= '0;
    else if (step) addr <= addr + 1'b1;
  end
endmodule

// File: rtl/rt_bus_arbiter.sv
module rt_bus_arbiter
  import rt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic drop,
  input  logic hold_req,
  input  logic ref_ready,
  output logic hold_ack,
  output logic ref_valid
);
  arb_state_t state_q, state_d;
  logic pend_q, pend_d;
  logic want, start;

  assign want  = (pend_q | tick) & ~drop;
  assign start = (state_q != ARB_REFRESH) && (state_d == ARB_REFRESH);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ARB_IDLE: begin
        if (want)          state_d = ARB_REFRESH;
        else if (hold_req) state_d = ARB_GRANT;
      end
      ARB_GRANT: begin
        if (want)           state_d = ARB_REVOKE;
        else if (!hold_req) state_d = ARB_IDLE;
      end
      ARB_REVOKE: begin
        if (!want)          state_d = ARB_IDLE;
        else if (!hold_req) state_d = ARB_REFRESH;
      end
      ARB_REFRESH: begin
        if (ref_ready) state_d = ARB_IDLE;
      end
      default: state_d = ARB_IDLE;
    endcase
  end

  assign pend_d = want & ~start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ARB_IDLE;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
    end
  end

  assign hold_ack  = (state_q == ARB_GRANT);
  assign ref_valid = (state_q == ARB_REFRESH);
endmodule

// File: rtl/refresh_req_timer.sv
module refresh_req_timer #(
  parameter int PW = 9,
  parameter int AW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic [PW-1:0] cfg_period,
  input  logic          cfg_enable,
  input  logic          hold_req,
  output logic          hold_ack,
  output logic          ref_valid,
  input  logic          ref_ready,
  output logic [AW-1:0] ref_addr
);
  logic en_q;
  logic tick;
  logic drop;
  logic accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      en_q <= 1'b0;
    else if (cfg_wr) en_q <= cfg_enable;
  end

  assign drop   = cfg_wr & ~cfg_enable;
  assign accept = ref_valid & ref_ready;

  rt_period_counter #(.PW(PW)) period_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cfg_wr),
    .load_val (cfg_period),
    .run      (en_q),
    .tick     (tick)
  );

  rt_bus_arbiter arb_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .drop      (drop),
    .hold_req  (hold_req),
    .ref_ready (ref_ready),
    .hold_ack  (hold_ack),
    .ref_valid (ref_valid)
  );

  rt_addr_counter #(.AW(AW)) addr_i (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (accept),
    .addr  (ref_addr)
  );
endmodule

// File: rtl/rt_checker.sv
module rt_checker #(
  parameter int AW = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          hold_req,
  input logic          hold_ack,
  input logic          ref_valid,
  input logic          ref_ready,
  input logic [AW-1:0] ref_addr
);
  assert_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(hold_ack && ref_valid));

  assert_no_regrant_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ref_valid |=> !hold_ack);

  assert_stall_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_valid && !ref_ready) |=> (ref_valid && $stable(ref_addr)));

  assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_valid && ref_ready) |=> (ref_addr == $past(ref_addr) + 1'b1));

  assert_addr_still_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(ref_valid && ref_ready) |=> $stable(ref_addr));

  assert_ack_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_req |=> !hold_ack);
endmodule

bind refresh_req_timer rt_checker #(.AW(AW)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .hold_req  (hold_req),
  .hold_ack  (hold_ack),
  .ref_valid (ref_valid),
  .ref_ready (ref_ready),
  .ref_addr  (ref_addr)
);

// File: tb/refresh_req_timer_tb_top.sv
module refresh_req_timer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [8:0] cfg_period = '0;
  logic       cfg_enable = 1'b0;
  logic       hold_req = 1'b0;
  logic       hold_ack;
  logic       ref_valid;
  logic       ref_ready = 1'b1;
  logic [8:0] ref_addr;

  int n_cmp = 0;
  int n_bad = 0;
  int exp_addr = 0;
  bit done = 0;

  always #2 clk = ~clk;

  refresh_req_timer dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_period(cfg_period),
    .cfg_enable(cfg_enable), .hold_req(hold_req), .hold_ack(hold_ack),
    .ref_valid(ref_valid), .ref_ready(ref_ready), .ref_addr(ref_addr)
  );

  task automatic check(input string tag, input int act, input int exp_v);
    n_cmp++;
    if (act != exp_v) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp_v);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic cfg(input int p, input bit en);
    cfg_wr = 1'b1; cfg_period = p[8:0]; cfg_enable = en;
    cyc();
    cfg_wr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int pulses;
    int a0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    cyc();
    // R1 reset state
    check("R1 hold_ack", hold_ack, 0);
    check("R1 ref_valid", ref_valid, 0);
    check("R1 ref_addr", ref_addr, 0);

    // R2/R4 sweep over periods with ready high
    for (int p = 2; p <= 16; p++) begin
      cfg(p, 1'b1);
      pulses = 0;
      for (int j = 1; j <= 4 * p; j++) begin
        cyc();
        check($sformatf("R2 valid P=%0d j=%0d", p, j), ref_valid, (j % p == 0) ? 1 : 0);
        if (ref_valid) begin
          pulses++;
          check("R4 addr", ref_addr, exp_addr);
          exp_addr = (exp_addr + 1) % 512;
        end
      end
      check($sformatf("R2 pulses P=%0d", p), pulses, 4);
    end

    // R3 disabled: no requests
    cfg(3, 1'b0);
    for (int j = 0; j < 40; j++) begin
      check("R3 valid while off", ref_valid, 0);
      cyc();
    end
    check("R4 addr idle", ref_addr, exp_addr);

    // R5 back-pressure, due during stall, then drop via R3
    ref_ready = 1'b0;
    cfg(5, 1'b1);
    for (int j = 1; j <= 4; j++) begin cyc(); check("R5 pre", ref_valid, 0); end
    cyc();
    check("R5 valid up", ref_valid, 1);
    a0 = ref_addr;
    check("R5 addr", a0, exp_addr);
    for (int j = 0; j < 7; j++) begin
      cyc();
      check("R5 valid held", ref_valid, 1);
      check("R5 addr stable", ref_addr, a0);
    end
    ref_ready = 1'b1;
    cyc();
    check("R5 handshake drop", ref_valid, 0);
    check("R4 addr after hs", ref_addr, (a0 + 1) % 512);
    cyc();
    check("R5 stalled due reissued", ref_valid, 1);
    cfg(5, 1'b0);
    exp_addr = (a0 + 2) % 512;
    check("R4 addr second", ref_addr, exp_addr);
    for (int j = 0; j < 30; j++) begin
      check("R3 pending dropped", ref_valid, 0);
      cyc();
    end

    // R6 grant and release
    hold_req = 1'b1;
    cyc();
    check("R6 grant", hold_ack, 1);
    hold_req = 1'b0;
    cyc();
    check("R6 release", hold_ack, 0);

    // R7/R8/R9 revoke sequence
    hold_req = 1'b1;
    cyc();
    check("R6 grant again", hold_ack, 1);
    ref_ready = 1'b0;
    cfg(40, 1'b1);
    for (int j = 1; j <= 39; j++) begin
      cyc();
      check("R7 ack before due", hold_ack, 1);
    end
    cyc();
    check("R7 revoked", hold_ack, 0);
    check("R7 no req under hold", ref_valid, 0);
    for (int j = 0; j < 5; j++) begin
      cyc();
      check("R7 waits", ref_valid, 0);
      check("R9 ack low", hold_ack, 0);
    end
    hold_req = 1'b0;
    cyc();
    check("R8 refresh starts", ref_valid, 1);
    hold_req = 1'b1;
    for (int j = 0; j < 4; j++) begin
      cyc();
      check("R9 no regrant", hold_ack, 0);
      check("R8 valid held", ref_valid, 1);
    end
    ref_ready = 1'b1;
    cyc();
    exp_addr = (exp_addr + 1) % 512;
    check("R9 handshake", ref_valid, 0);
    check("R9 ack at hs", hold_ack, 0);
    check("R4 addr after revoke", ref_addr, exp_addr);
    cyc();
    check("R9 regrant", hold_ack, 1);
    cfg(40, 1'b0);
    hold_req = 1'b0;
    cyc();
    check("R6 dropped", hold_ack, 0);

    // R10 enable cleared while revoked
    hold_req = 1'b1;
    cyc();
    check("R6 grant R10 setup", hold_ack, 1);
    cfg(6, 1'b1);
    for (int j = 1; j <= 6; j++) cyc();
    check("R10 revoked", hold_ack, 0);
    cfg(6, 1'b0);
    check("R10 after drop ack", hold_ack, 0);
    check("R10 after drop valid", ref_valid, 0);
    cyc();
    check("R10 regrant", hold_ack, 1);
    for (int j = 0; j < 20; j++) begin
      cyc();
      check("R10 stays granted", hold_ack, 1);
      check("R10 no refresh", ref_valid, 0);
    end
    check("R10 addr", ref_addr, exp_addr);
    hold_req = 1'b0;
    cyc();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule